// File: doc/BRIEF.md
# Serial Receive Interrupt and Special-Condition Controller

This block decides when a serial receive channel asks the processor for service. Each character that the receiver pushes into its FIFO arrives as a one-cycle event with error flags attached. The block sorts the character as ordinary data, as a special condition, or as a stripped synchronisation character. It then raises or holds a receive interrupt request according to a two-bit mode. It also produces a two-bit code that the interrupt vector logic folds into the vector it returns.

In two of the modes an errored character freezes the FIFO. It stays frozen until software issues an error-reset command, so the bad byte and its status stay together. Overrun and parity-error status bits are sticky. A separate transmit request fires when the transmit buffer becomes empty.

Every output is a register or is decoded from registers only. A stimulus applied in the cycle before a rising edge is therefore visible just after that edge.

Top module: `rxirq_ctrl`

## Requirements
- R1: `cfg_mode` selects the behaviour: 2'b00 off, 2'b01 first character, 2'b10 every character, 2'b11 special only. In mode 2'b00 `rx_irq` stays 0, but a special condition still sets `vec_code` to 2'b11.
- R2: A pushed character is a special condition when at least one of these holds:
  - overrun is flagged;
  - framing error is flagged;
  - end of frame is flagged and buffered frame status is not enabled;
  - parity error is flagged while both `cfg_par_en` and `cfg_par_special` are 1.
- R3: A push with `push_sync`=1 has no effect on any output and does not consume the first-character arming.
- R4: In mode 2'b01 only the first ordinary character after reset, `chan_reset` or `cmd_rearm` raises the data request. The request drops once `fifo_nempty` is 0.
- R5: In mode 2'b10 the data request follows `fifo_nempty`. A special condition raises `rx_irq` with `vec_code` 2'b11 but never sets `fifo_lock`.
- R6: In modes 2'b01 and 2'b11 a special condition sets `fifo_lock` and holds it. The lock clears on `cmd_err_reset`, on `chan_reset`, on a change of mode to 2'b00, or on any mode without locking.
- R7: `stat_ovr` (any overrun) and `stat_par` (parity error while parity is enabled) are sticky. Only `cmd_err_reset` clears them, and a new error in the same cycle wins over the clear.
- R8: With `cfg_sdlc`=1 and `cfg_fsbuf`=1, an end of frame is treated as receive data available. In mode 2'b11 it raises `rx_irq` with `vec_code` 2'b10 and leaves `fifo_lock` at 0.
- R9: `vec_code` is 2'b11 while a special condition is pending, otherwise 2'b10 while data is requested, otherwise 2'b00. It is never 2'b01.
- R10: With `cfg_tx_ie`=1, a 0-to-1 change of `tx_empty` sets `tx_irq`. `tx_write` or `cfg_tx_ie`=0 clears it.
- R11: While `rst` is high at a clock edge, every output reads 0 afterwards. All outputs change only at the clock edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_reset | input | 1 | Channel reset command pulse |
| push | input | 1 | A received character enters the FIFO |
| push_ovr | input | 1 | Character flagged with overrun |
| push_frm | input | 1 | Character flagged with framing error |
| push_eof | input | 1 | Character ends a frame |
| push_par | input | 1 | Character has a parity error |
| push_sync | input | 1 | Character is a stripped sync character |
| fifo_nempty | input | 1 | Receive FIFO holds data |
| cmd_err_reset | input | 1 | Error-reset command pulse |
| cmd_rearm | input | 1 | Re-arm first-character interrupt |
| cfg_mode | input | 2 | Receive interrupt mode |
| cfg_par_en | input | 1 | Parity checking enabled |
| cfg_par_special | input | 1 | Parity error counts as special |
| cfg_sdlc | input | 1 | Bit-oriented framing mode |
| cfg_fsbuf | input | 1 | Frame status buffering enabled |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| tx_empty | input | 1 | Transmit buffer empty |
| tx_write | input | 1 | Transmit buffer written |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| fifo_lock | output | 1 | Hold the receive FIFO |
| stat_ovr | output | 1 | Sticky overrun status |
| stat_par | output | 1 | Sticky parity-error status |
| vec_code | output | 2 | Vector modifier code |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which its stimulus is applied. This holds for the lock, the sticky bits, the vector code, the receive request and the transmit edge request alike, and no output has a longer path.

The bench drives stimulus on the falling edge and lets a behavioural model advance on the same rising edge as the design. It compares all six outputs on the following falling edge. Each scripted scenario also reads the outputs at the falling edge right after its stimulus edge, so every directed expectation lands on the first cycle the result can appear.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    typedef enum logic [1:0] {
        RXM_OFF   = 2'b00,
        RXM_FIRST = 2'b01,
        RXM_ALL   = 2'b10,
        RXM_SPEC  = 2'b11
    } rx_mode_e;

    typedef enum logic [1:0] {
        VEC_NONE    = 2'b00,
        VEC_DATA    = 2'b10,
        VEC_SPECIAL = 2'b11
    } vec_code_e;

    // one received character after sync filtering
    typedef struct packed {
        logic valid;
        logic overrun;
        logic framing;
        logic eof;
        logic parity;
    } rx_event_t;

    // classification of that character
    typedef struct packed {
        logic special;
        logic eof_buffered;
        logic data_char;
        logic parity_seen;
        logic overrun_seen;
    } rx_class_t;

    function automatic logic mode_locks(rx_mode_e m);
        return (m == RXM_FIRST) || (m == RXM_SPEC);
    endfunction

    function automatic vec_code_e vec_select(logic spec, logic data);
        if (spec)      return VEC_SPECIAL;
        else if (data) return VEC_DATA;
        else           return VEC_NONE;
    endfunction

endpackage

// File: rtl/rxirq_classify.sv
module rxirq_classify
    import rxirq_pkg::*;
(
    input  rx_event_t ev,
    input  logic      par_en,
    input  logic      par_special,
    input  logic      sdlc,
    input  logic      fsbuf,
    output rx_class_t cls
);
    logic eof_buf;
    logic par_counts;

    always_comb begin
        eof_buf          = ev.eof & sdlc & fsbuf;
        par_counts       = ev.parity & par_en & par_special;
        cls.eof_buffered = ev.valid & eof_buf;
        cls.special      = ev.valid & (ev.overrun | ev.framing | par_counts
                                       | (ev.eof & ~eof_buf));
        cls.data_char    = ev.valid;
        cls.parity_seen  = ev.valid & ev.parity & par_en;
        cls.overrun_seen = ev.valid & ev.overrun;
    end
endmodule

// File: rtl/rxirq_rx_state.sv
module rxirq_rx_state
    import rxirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_class_t cls,
    input  rx_mode_e  mode,
    input  logic      fifo_nempty,
    input  logic      err_reset,
    input  logic      rearm,
    input  logic      chan_reset,
    output logic      spec_q,
    output logic      lock_q,
    output logic      data_q,
    output logic      ovr_q,
    output logic      par_q,
    output rx_mode_e  mode_q
);
    logic arm_q;
    logic leaving, clr_cond;
    logic spec_d, lock_d, data_d, ovr_d, par_d, arm_d, data_set;

    always_comb begin
        leaving  = (mode == RXM_OFF) && (mode_q != RXM_OFF);
        clr_cond = err_reset | chan_reset | leaving;

        spec_d = cls.special | (spec_q & ~clr_cond);
        lock_d = mode_locks(mode) & (cls.special | (lock_q & ~clr_cond));

        if (chan_reset || rearm)
            arm_d = 1'b1;
        else if (cls.data_char && mode == RXM_FIRST)
            arm_d = 1'b0;
        else
            arm_d = arm_q;

        unique case (mode)
            RXM_ALL:   data_set = fifo_nempty;
            RXM_FIRST: data_set = arm_q & cls.data_char;
            RXM_SPEC:  data_set = cls.eof_buffered;
            default:   data_set = 1'b0;
        endcase
        data_d = (mode != RXM_OFF) & ~chan_reset
                 & (data_set | (data_q & fifo_nempty));

        ovr_d = cls.overrun_seen | (ovr_q & ~err_reset);
        par_d = cls.parity_seen  | (par_q & ~err_reset);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_q <= 1'b0;
            lock_q <= 1'b0;
            data_q <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            arm_q  <= 1'b1;
            mode_q <= RXM_OFF;
        end else begin
            spec_q <= spec_d;
            lock_q <= lock_d;
            data_q <= data_d;
            ovr_q  <= ovr_d;
            par_q  <= par_d;
            arm_q  <= arm_d;
            mode_q <= mode;
        end
    end
endmodule

// File: rtl/rxirq_tx_req.sv
module rxirq_tx_req (
    input  logic clk,
    input  logic rst,
    input  logic tx_ie,
    input  logic tx_empty,
    input  logic tx_write,
    output logic tx_irq
);
    logic empty_q;
    logic req_d;

    always_comb begin
        req_d = tx_ie & ((tx_empty & ~empty_q) | (tx_irq & ~tx_write));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b0;
            tx_irq  <= 1'b0;
        end else begin
            empty_q <= tx_empty;
            tx_irq  <= req_d;
        end
    end
endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl
    import rxirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_reset,
    input  logic       push,
    input  logic       push_ovr,
    input  logic       push_frm,
    input  logic       push_eof,
    input  logic       push_par,
    input  logic       push_sync,
    input  logic       fifo_nempty,
    input  logic       cmd_err_reset,
    input  logic       cmd_rearm,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_par_en,
    input  logic       cfg_par_special,
    input  logic       cfg_sdlc,
    input  logic       cfg_fsbuf,
    input  logic       cfg_tx_ie,
    input  logic       tx_empty,
    input  logic       tx_write,
    output logic       rx_irq,
    output logic       tx_irq,
    output logic       fifo_lock,
    output logic       stat_ovr,
    output logic       stat_par,
    output logic [1:0] vec_code
);
    rx_event_t ev;
    rx_class_t cls;
    rx_mode_e  mode_in, mode_q;
    logic      spec_q, data_q;

    always_comb begin
        mode_in    = rx_mode_e'(cfg_mode);
        ev.valid   = push & ~push_sync;
        ev.overrun = push_ovr;
        ev.framing = push_frm;
        ev.eof     = push_eof;
        ev.parity  = push_par;
    end

    rxirq_classify u_classify (
        .ev          (ev),
        .par_en      (cfg_par_en),
        .par_special (cfg_par_special),
        .sdlc        (cfg_sdlc),
        .fsbuf       (cfg_fsbuf),
        .cls         (cls)
    );

    rxirq_rx_state u_state (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .mode        (mode_in),
        .fifo_nempty (fifo_nempty),
        .err_reset   (cmd_err_reset),
        .rearm       (cmd_rearm),
        .chan_reset  (chan_reset),
        .spec_q      (spec_q),
        .lock_q      (fifo_lock),
        .data_q      (data_q),
        .ovr_q       (stat_ovr),
        .par_q       (stat_par),
        .mode_q      (mode_q)
    );

    rxirq_tx_req u_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_ie    (cfg_tx_ie),
        .tx_empty (tx_empty),
        .tx_write (tx_write),
        .tx_irq   (tx_irq)
    );

    always_comb begin
        rx_irq   = (mode_q != RXM_OFF) & (spec_q | data_q);
        vec_code = vec_select(spec_q, data_q);
    end
endmodule

// File: rtl/rxirq_ctrl_chk.sv
module rxirq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       chan_reset,
    input logic       cmd_err_reset,
    input logic [1:0] cfg_mode,
    input logic       cfg_tx_ie,
    input logic       rx_irq,
    input logic       tx_irq,
    input logic       fifo_lock,
    input logic       stat_ovr,
    input logic       stat_par,
    input logic [1:0] vec_code
);
    assert_quiet_off_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00) |=> !rx_irq);

    assert_no_lock_all_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b10) |=> !fifo_lock);

    assert_lock_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (fifo_lock && !cmd_err_reset && !chan_reset
         && (cfg_mode == 2'b01 || cfg_mode == 2'b11)) |=> fifo_lock);

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_ovr && !cmd_err_reset) |=> stat_ovr);

    assert_par_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_par && !cmd_err_reset) |=> stat_par);

    assert_lock_means_special_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_lock |-> (vec_code == 2'b11));

    assert_no_code01_R9: assert property (@(posedge clk) disable iff (rst)
        vec_code != 2'b01);

    assert_tx_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_tx_ie |=> !tx_irq);
endmodule

bind rxirq_ctrl rxirq_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .chan_reset    (chan_reset),
    .cmd_err_reset (cmd_err_reset),
    .cfg_mode      (cfg_mode),
    .cfg_tx_ie     (cfg_tx_ie),
    .rx_irq        (rx_irq),
    .tx_irq        (tx_irq),
    .fifo_lock     (fifo_lock),
    .stat_ovr      (stat_ovr),
    .stat_par      (stat_par),
    .vec_code      (vec_code)
);

// File: tb/rxirq_ctrl_tb_top.sv
module rxirq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_reset = 0, push = 0, push_ovr = 0, push_frm = 0, push_eof = 0;
    logic push_par = 0, push_sync = 0, fifo_nempty = 0, cmd_err_reset = 0, cmd_rearm = 0;
    logic [1:0] cfg_mode = 2'b01;
    logic cfg_par_en = 1, cfg_par_special = 1, cfg_sdlc = 0, cfg_fsbuf = 0, cfg_tx_ie = 0;
    logic tx_empty = 0, tx_write = 0;
    logic rx_irq, tx_irq, fifo_lock, stat_ovr, stat_par;
    logic [1:0] vec_code;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxirq_ctrl dut_i (
        .clk(clk), .rst(rst), .chan_reset(chan_reset), .push(push),
        .push_ovr(push_ovr), .push_frm(push_frm), .push_eof(push_eof),
        .push_par(push_par), .push_sync(push_sync), .fifo_nempty(fifo_nempty),
        .cmd_err_reset(cmd_err_reset), .cmd_rearm(cmd_rearm), .cfg_mode(cfg_mode),
        .cfg_par_en(cfg_par_en), .cfg_par_special(cfg_par_special),
        .cfg_sdlc(cfg_sdlc), .cfg_fsbuf(cfg_fsbuf), .cfg_tx_ie(cfg_tx_ie),
        .tx_empty(tx_empty), .tx_write(tx_write), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .fifo_lock(fifo_lock), .stat_ovr(stat_ovr), .stat_par(stat_par),
        .vec_code(vec_code)
    );

    // behavioural reference model
    bit m_spec, m_lock, m_data, m_ovr, m_par, m_arm, m_tx, m_txe;
    int m_mode;
    bit good, special, fsb_eof, wipe, lockable;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_spec <= 0; m_lock <= 0; m_data <= 0; m_ovr <= 0; m_par <= 0;
            m_arm <= 1; m_tx <= 0; m_txe <= 0; m_mode <= 0;
        end else begin
            good     = push && !push_sync;
            fsb_eof  = push_eof && cfg_sdlc && cfg_fsbuf;
            special  = good && (push_ovr || push_frm || (push_eof && !fsb_eof)
                                || (push_par && cfg_par_en && cfg_par_special));
            wipe     = cmd_err_reset || chan_reset || (cfg_mode == 0 && m_mode != 0);
            lockable = (cfg_mode == 1) || (cfg_mode == 3);
            m_spec <= special ? 1 : (wipe ? 0 : m_spec);
            m_lock <= !lockable ? 0 : (special ? 1 : (wipe ? 0 : m_lock));
            if (chan_reset || cmd_rearm) m_arm <= 1;
            else if (good && cfg_mode == 1) m_arm <= 0;
            if (cfg_mode == 0 || chan_reset) m_data <= 0;
            else if ((cfg_mode == 2 && fifo_nempty) || (cfg_mode == 1 && m_arm && good)
                     || (cfg_mode == 3 && good && fsb_eof)) m_data <= 1;
            else if (!fifo_nempty) m_data <= 0;
            if (good && push_ovr) m_ovr <= 1; else if (cmd_err_reset) m_ovr <= 0;
            if (good && push_par && cfg_par_en) m_par <= 1; else if (cmd_err_reset) m_par <= 0;
            if (!cfg_tx_ie) m_tx <= 0;
            else if (tx_empty && !m_txe) m_tx <= 1;
            else if (tx_write) m_tx <= 0;
            m_txe <= tx_empty;
            m_mode <= cfg_mode;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("R4 model rx_irq", rx_irq, (m_mode != 0) && (m_spec || m_data));
            chk("R6 model fifo_lock", fifo_lock, m_lock);
            chk("R7 model stat_ovr", stat_ovr, m_ovr);
            chk("R7 model stat_par", stat_par, m_par);
            chk("R9 model vec_code", vec_code, m_spec ? 3 : (m_data ? 2 : 0));
            chk("R10 model tx_irq", tx_irq, m_tx);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        push = 0; push_ovr = 0; push_frm = 0; push_eof = 0; push_par = 0; push_sync = 0;
        cmd_err_reset = 0; cmd_rearm = 0; chan_reset = 0; tx_write = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R11 reset state
        chk("R11 rx_irq reset", rx_irq, 0);
        chk("R11 lock reset", fifo_lock, 0);
        chk("R11 vec reset", vec_code, 0);
        chk("R11 tx reset", tx_irq, 0);
        rst = 0;
        tick();

        // R4 first character only, rearm
        push = 1; fifo_nempty = 1; tick();
        chk("R4 first char irq", rx_irq, 1);
        chk("R4 first char vec", vec_code, 2);
        fifo_nempty = 0; tick();
        chk("R4 drop on empty", rx_irq, 0);
        push = 1; fifo_nempty = 1; tick();
        chk("R4 second char silent", rx_irq, 0);
        fifo_nempty = 0; cmd_rearm = 1; tick();
        chk("R4 rearm alone silent", rx_irq, 0);
        push = 1; fifo_nempty = 1; tick();
        chk("R4 rearmed char irq", rx_irq, 1);
        fifo_nempty = 0; tick();

        // R3 sync characters are ignored
        cmd_rearm = 1; tick();
        push = 1; push_sync = 1; push_ovr = 1; tick();
        chk("R3 sync no ovr", stat_ovr, 0);
        chk("R3 sync no irq", rx_irq, 0);
        chk("R3 sync no vec", vec_code, 0);
        push = 1; fifo_nempty = 1; tick();
        chk("R3 arm kept", rx_irq, 1);
        fifo_nempty = 0; tick();

        // R6 / R2 framing error locks in mode 01
        push = 1; push_frm = 1; fifo_nempty = 1; tick();
        chk("R6 lock set", fifo_lock, 1);
        chk("R2 framing special", vec_code, 3);
        tick(); tick();
        chk("R6 lock held", fifo_lock, 1);
        cmd_err_reset = 1; fifo_nempty = 0; tick();
        chk("R6 lock cleared", fifo_lock, 0);
        chk("R6 vec cleared", vec_code, 0);

        // R2 parity special only when both bits set; R7 parity sticky
        cfg_par_special = 0; push = 1; push_par = 1; tick();
        chk("R2 parity not special", fifo_lock, 0);
        chk("R7 parity latched", stat_par, 1);
        cfg_par_special = 1; cfg_par_en = 0; push = 1; push_par = 1; tick();
        chk("R2 parity disabled", fifo_lock, 0);
        chk("R7 parity sticky", stat_par, 1);
        cfg_par_en = 1; cmd_err_reset = 1; tick();
        chk("R7 parity cleared", stat_par, 0);

        // R7 set wins over same-cycle error reset
        push = 1; push_ovr = 1; cmd_err_reset = 1; tick();
        chk("R7 ovr set wins", stat_ovr, 1);
        chk("R6 lock set wins", fifo_lock, 1);
        cmd_err_reset = 1; tick();
        chk("R7 ovr cleared", stat_ovr, 0);

        // R1 mode off
        cfg_mode = 2'b00; push = 1; push_frm = 1; tick();
        chk("R1 off no irq", rx_irq, 0);
        chk("R1 off vec special", vec_code, 3);
        cmd_err_reset = 1; tick();
        chk("R1 off vec cleared", vec_code, 0);
        cfg_mode = 2'b11; push = 1; push_ovr = 1; tick();
        chk("R6 mode11 lock", fifo_lock, 1);
        cfg_mode = 2'b00; tick();
        chk("R6 disable clears lock", fifo_lock, 0);
        chk("R6 disable clears vec", vec_code, 0);
        chk("R7 ovr survives disable", stat_ovr, 1);
        cmd_err_reset = 1; tick();

        // R5 every character mode
        cfg_mode = 2'b10; fifo_nempty = 1; tick();
        chk("R5 data irq", rx_irq, 1);
        chk("R5 data vec", vec_code, 2);
        push = 1; push_frm = 1; tick();
        chk("R5 no lock", fifo_lock, 0);
        chk("R5 special vec", vec_code, 3);
        fifo_nempty = 0; cmd_err_reset = 1; tick();
        chk("R5 idle", rx_irq, 0);

        // R8 buffered end of frame
        cfg_mode = 2'b11; cfg_sdlc = 1; cfg_fsbuf = 1;
        push = 1; push_eof = 1; fifo_nempty = 1; tick();
        chk("R8 eof data vec", vec_code, 2);
        chk("R8 eof irq", rx_irq, 1);
        chk("R8 eof no lock", fifo_lock, 0);
        fifo_nempty = 0; tick();
        chk("R8 eof drops", rx_irq, 0);
        cfg_fsbuf = 0; push = 1; push_eof = 1; tick();
        chk("R2 eof special", fifo_lock, 1);
        chan_reset = 1; tick();
        chk("R6 chan reset lock", fifo_lock, 0);
        chk("R6 chan reset vec", vec_code, 0);

        // R10 transmit request
        cfg_tx_ie = 1; tx_empty = 1; tick();
        chk("R10 tx edge", tx_irq, 1);
        tick();
        chk("R10 tx held", tx_irq, 1);
        tx_write = 1; tick();
        chk("R10 tx cleared by write", tx_irq, 0);
        tx_empty = 0; tick();
        tx_empty = 1; tick();
        chk("R10 tx edge again", tx_irq, 1);
        cfg_tx_ie = 0; tick();
        chk("R10 tx disabled", tx_irq, 0);
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule